// File: doc/BRIEF.md
# Debug Command Sequencer

This block turns one debug operation into the series of 17-bit words that a serial debug master shifts into a halted target processor. The operations are: read or write a data/address register, read or write a system register, read or write memory at byte, word or long size, resume execution, pulse the peripheral reset, and a null operation. For each operation the sequencer sends a command word, then any address or data words. It then sends null words to collect the replies, because a reply always arrives during the transfer that follows the word it answers. Each reply is sorted into data, completion, not-ready, bus error, illegal command or an unexpected pattern. A read's data words are assembled into a 32-bit value. A not-ready reply is retried only a bounded number of times.

A requester presents an operation on a valid/ready pair. The sequencer holds one word at a time on its transfer port and waits for the serial master's done strobe, which also carries the reply. When the operation ends, one result strobe returns the assembled data and an error code.

The controller has four states. **IDLE** waits for a request and moves to **SEND** when it accepts one. **SEND** steps through the command and extension words and moves to **COLLECT** once the last of them is done. **COLLECT** sends null words and decodes each reply: a not-ready reply under the limit stays in COLLECT, and so does a data word that is not the last one expected. A final data word, a completion, or any error moves to **REPORT**. **REPORT** presents the result for one cycle and returns to IDLE.

Top module: `dbgseq_top`

## Requirements
- R1: After reset, req_ready is 1, and xf_req, res_valid, res_data and res_err are all 0.
- R2: The first word of each operation is its command word. Bit 16 is 0 and the low 16 bits are: register read 16'h2180 OR reg, register write 16'h2080 OR reg, system-register read 16'h2580 OR reg, system-register write 16'h2480 OR reg, memory read 16'h1900 OR size code, memory write 16'h1800 OR size code, resume 16'h0C00, peripheral reset 16'h0400, null 16'h0000. The op codes are 0 null, 1 register read, 2 register write, 3 system-register read, 4 system-register write, 5 memory read, 6 memory write, 7 resume, 8 peripheral reset. Codes 9 to 15 behave as null.
- R3: req_size 0 selects byte (size code 16'h00), 1 selects word (16'h40), and 2 or 3 select long (16'h80).
- R4: Register and system-register writes send two extension words after the command: wdata[31:16], then wdata[15:0]. Memory operations send addr[31:16], then addr[15:0]. A memory write then sends its data. For long this is wdata[31:16] followed by wdata[15:0]. For word it is wdata[15:0]. For byte it is {8'h00, wdata[7:0]}.
- R5: Every transmitted word has bit 16 at 0. While xf_req is high and xf_done is low, xf_req stays high and xf_tx stays unchanged.
- R6: Replies received while command or extension words are being sent are ignored, whatever their value.
- R7: Once the last command or extension word is done, the sequencer sends null words (17'h00000) to collect replies. For reads, every reply with bit 16 at 0 is a data word. Register and system-register reads take two words, high word first. Memory reads take two words at long size and one word otherwise. A byte read returns only bits 7:0, and a word read is zero-extended.
- R8: A reply of 17'h10000 (not ready) causes another null word to be sent. The count of consecutive not-ready replies restarts after each data word. If a not-ready reply arrives when MAX_RETRY retries have already been made, the operation ends with error 3 (timeout).
- R9: A reply of 17'h10001 ends the operation with error 1 (bus error). A reply of 17'h1FFFF ends it with error 2 (illegal command). Any other reply with bit 16 at 1 ends it with error 4 (protocol).
- R10: A non-read operation ends with error 0 on the reply 17'h0FFFF. Any other reply with bit 16 at 0 ends it with error 4.
- R11: res_valid is high for exactly one cycle, in the cycle after the xf_done that ends the operation. res_data is the assembled value when the error is 0 and is 0 otherwise. res_data and res_err hold their values until the next result.
- R12: req_ready is high only in IDLE. A request presented while req_ready is low is ignored and does not change the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request valid |
| req_ready | output | 1 | Sequencer idle; accepts a request |
| req_op | input | 4 | Operation code |
| req_reg | input | 4 | Register selector, ORed into register command words |
| req_size | input | 2 | Access size for memory operations |
| req_addr | input | 32 | Memory address |
| req_wdata | input | 32 | Write data |
| res_valid | output | 1 | Result strobe, one cycle |
| res_data | output | 32 | Assembled read data |
| res_err | output | 3 | 0 ok, 1 bus error, 2 illegal, 3 timeout, 4 protocol |
| xf_req | output | 1 | Word transfer requested from the serial master |
| xf_tx | output | 17 | Word to transmit |
| xf_done | input | 1 | Transfer finished; xf_rx valid |
| xf_rx | input | 17 | Reply shifted in during the finished transfer |

## Verification
If the word index or the extension-word count is wrong, the error shows up within one transfer as a wrong xf_tx value, or as a missing or extra word before the null words begin. A wrong reply-class decision or a wrong retry count appears as a wrong res_err in the REPORT cycle that follows the deciding reply. A data-assembly error shows as a wrong res_data in that same cycle. A state that fails to return to IDLE shows up as a missing or lengthened result strobe, or as a new request that is never accepted.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;

    localparam int WORD_W = 16;
    localparam int XF_W   = WORD_W + 1;
    localparam int DATA_W = 2 * WORD_W;
    localparam int IDX_W  = 3;
    localparam int RXN_W  = 2;

    localparam logic [3:0] OP_NOP        = 4'd0;
    localparam logic [3:0] OP_REG_RD     = 4'd1;
    localparam logic [3:0] OP_REG_WR     = 4'd2;
    localparam logic [3:0] OP_SREG_RD    = 4'd3;
    localparam logic [3:0] OP_SREG_WR    = 4'd4;
    localparam logic [3:0] OP_MEM_RD     = 4'd5;
    localparam logic [3:0] OP_MEM_WR     = 4'd6;
    localparam logic [3:0] OP_GO         = 4'd7;
    localparam logic [3:0] OP_RST_PERIPH = 4'd8;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;

    localparam logic [WORD_W-1:0] BASE_REG_RD  = 16'h2180;
    localparam logic [WORD_W-1:0] BASE_REG_WR  = 16'h2080;
    localparam logic [WORD_W-1:0] BASE_SREG_RD = 16'h2580;
    localparam logic [WORD_W-1:0] BASE_SREG_WR = 16'h2480;
    localparam logic [WORD_W-1:0] BASE_MEM_RD  = 16'h1900;
    localparam logic [WORD_W-1:0] BASE_MEM_WR  = 16'h1800;
    localparam logic [WORD_W-1:0] CODE_GO      = 16'h0C00;
    localparam logic [WORD_W-1:0] CODE_RSTP    = 16'h0400;
    localparam logic [WORD_W-1:0] CODE_NULL    = 16'h0000;

    localparam logic [XF_W-1:0] RX_NOTRDY  = 17'h10000;
    localparam logic [XF_W-1:0] RX_BUSERR  = 17'h10001;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_BUS      = 3'd1,
        ERR_ILLEGAL  = 3'd2,
        ERR_TIMEOUT  = 3'd3,
        ERR_PROTOCOL = 3'd4
    } err_e;

    typedef enum logic [2:0] {
        RC_DATA,
        RC_DONE,
        RC_NOTRDY,
        RC_BERR,
        RC_ILLEGAL,
        RC_OTHER
    } resp_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SEND,
        S_COLLECT,
        S_REPORT
    } state_e;

endpackage

// File: rtl/dbgseq_encoder.sv
module dbgseq_encoder
    import dbgseq_pkg::*;
(
    input  logic [3:0]        op,
    input  logic [3:0]        regsel,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word,
    output logic [IDX_W-1:0]  n_tx,
    output logic [RXN_W-1:0]  n_rx
);

    logic [WORD_W-1:0] cmd;
    logic [WORD_W-1:0] size_code;
    logic [WORD_W-1:0] mem_data_word;
    logic [WORD_W-1:0] reg_field;
    logic              long_sz;
    logic              is_mem;

    always_comb begin
        long_sz   = size[1];
        reg_field = {{(WORD_W-4){1'b0}}, regsel};
        if (long_sz)
            size_code = 16'h0080;
        else if (size == SZ_WORD)
            size_code = 16'h0040;
        else
            size_code = 16'h0000;

        if (long_sz)
            mem_data_word = wdata[DATA_W-1 -: WORD_W];
        else if (size == SZ_WORD)
            mem_data_word = wdata[WORD_W-1:0];
        else
            mem_data_word = {8'h00, wdata[7:0]};
    end

    always_comb begin
        cmd    = CODE_NULL;
        n_tx   = IDX_W'(1);
        n_rx   = '0;
        is_mem = 1'b0;
        case (op)
            OP_REG_RD: begin
                cmd  = BASE_REG_RD | reg_field;
                n_rx = RXN_W'(2);
            end
            OP_REG_WR: begin
                cmd  = BASE_REG_WR | reg_field;
                n_tx = IDX_W'(3);
            end
            OP_SREG_RD: begin
                cmd  = BASE_SREG_RD | reg_field;
                n_rx = RXN_W'(2);
            end
            OP_SREG_WR: begin
                cmd  = BASE_SREG_WR | reg_field;
                n_tx = IDX_W'(3);
            end
            OP_MEM_RD: begin
                cmd    = BASE_MEM_RD | size_code;
                n_tx   = IDX_W'(3);
                n_rx   = long_sz ? RXN_W'(2) : RXN_W'(1);
                is_mem = 1'b1;
            end
            OP_MEM_WR: begin
                cmd    = BASE_MEM_WR | size_code;
                n_tx   = long_sz ? IDX_W'(5) : IDX_W'(4);
                is_mem = 1'b1;
            end
            OP_GO:         cmd = CODE_GO;
            OP_RST_PERIPH: cmd = CODE_RSTP;
            default:       cmd = CODE_NULL;
        endcase
    end

    always_comb begin
        case (idx)
            IDX_W'(0): word = cmd;
            IDX_W'(1): word = is_mem ? addr[DATA_W-1 -: WORD_W] : wdata[DATA_W-1 -: WORD_W];
            IDX_W'(2): word = is_mem ? addr[WORD_W-1:0]        : wdata[WORD_W-1:0];
            IDX_W'(3): word = mem_data_word;
            IDX_W'(4): word = wdata[WORD_W-1:0];
            default:   word = CODE_NULL;
        endcase
    end

endmodule

// File: rtl/dbgseq_resp_decode.sv
module dbgseq_resp_decode
    import dbgseq_pkg::*;
(
    input  logic [XF_W-1:0]   rx,
    output resp_e             cls,
    output logic [WORD_W-1:0] payload
);

    logic flag;

    always_comb begin
        flag    = rx[XF_W-1];
        payload = rx[WORD_W-1:0];
        if (!flag)
            cls = (payload == {WORD_W{1'b1}}) ? RC_DONE : RC_DATA;
        else if (payload == {WORD_W{1'b0}})
            cls = RC_NOTRDY;
        else if (payload == WORD_W'(1))
            cls = RC_BERR;
        else if (payload == {WORD_W{1'b1}})
            cls = RC_ILLEGAL;
        else
            cls = RC_OTHER;
    end

endmodule

// File: rtl/dbgseq_retry.sv
module dbgseq_retry #(
    parameter int MAX_RETRY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);

    localparam int CNT_W = $clog2(MAX_RETRY + 2);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign at_limit = (cnt_q == CNT_W'(MAX_RETRY));

    AST_RETRY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_RETRY)); // R8

    AST_NO_INC_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !clr |-> !at_limit); // R8

endmodule

// File: rtl/dbgseq_top.sv
module dbgseq_top
    import dbgseq_pkg::*;
#(
    parameter int MAX_RETRY = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_op,
    input  logic [3:0]        req_reg,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_wdata,
    output logic              res_valid,
    output logic [31:0]       res_data,
    output logic [2:0]        res_err,
    output logic              xf_req,
    output logic [16:0]       xf_tx,
    input  logic              xf_done,
    input  logic [16:0]       xf_rx
);

    state_e state_q, state_d;

    logic [3:0]        op_q;
    logic [3:0]        reg_q;
    logic [1:0]        size_q;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [IDX_W-1:0]  idx_q;
    logic [RXN_W-1:0]  got_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] res_data_q;
    err_e              res_err_q;

    logic [WORD_W-1:0] enc_word;
    logic [IDX_W-1:0]  n_tx;
    logic [RXN_W-1:0]  n_rx;
    resp_e             cls;
    logic [WORD_W-1:0] payload;
    logic              at_limit;

    logic              accept;
    logic              fin;
    err_e              fin_err;
    logic              take;
    logic              rinc;
    logic              rclr;
    logic              is_read;
    logic [DATA_W-1:0] asm_data;

    dbgseq_encoder u_enc (
        .op     (op_q),
        .regsel (reg_q),
        .size   (size_q),
        .addr   (addr_q),
        .wdata  (wdata_q),
        .idx    (idx_q),
        .word   (enc_word),
        .n_tx   (n_tx),
        .n_rx   (n_rx)
    );

    dbgseq_resp_decode u_dec (
        .rx      (xf_rx),
        .cls     (cls),
        .payload (payload)
    );

    dbgseq_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rclr),
        .inc      (rinc),
        .at_limit (at_limit)
    );

    assign is_read = (n_rx != '0);
    assign accept  = (state_q == S_IDLE) && req_valid;

    always_comb begin
        asm_data = {data_q[WORD_W-1:0], payload};
        if (op_q == OP_MEM_RD && size_q == SZ_BYTE)
            asm_data = asm_data & DATA_W'(8'hFF);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // next state and per-reply decisions
    always_comb begin
        state_d = state_q;
        fin     = 1'b0;
        fin_err = ERR_NONE;
        take    = 1'b0;
        rinc    = 1'b0;
        rclr    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    state_d = S_SEND;
                    rclr    = 1'b1;
                end
            end
            S_SEND: begin
                if (xf_done && idx_q == n_tx - IDX_W'(1))
                    state_d = S_COLLECT;
            end
            S_COLLECT: begin
                if (xf_done) begin
                    case (cls)
                        RC_NOTRDY: begin
                            if (at_limit) begin
                                fin     = 1'b1;
                                fin_err = ERR_TIMEOUT;
                            end else begin
                                rinc = 1'b1;
                            end
                        end
                        RC_BERR: begin
                            fin     = 1'b1;
                            fin_err = ERR_BUS;
                        end
                        RC_ILLEGAL: begin
                            fin     = 1'b1;
                            fin_err = ERR_ILLEGAL;
                        end
                        RC_OTHER: begin
                            fin     = 1'b1;
                            fin_err = ERR_PROTOCOL;
                        end
                        default: begin
                            if (is_read) begin
                                take = 1'b1;
                                rclr = 1'b1;
                                if (got_q + RXN_W'(1) == n_rx)
                                    fin = 1'b1;
                            end else begin
                                fin = 1'b1;
                                if (cls != RC_DONE)
                                    fin_err = ERR_PROTOCOL;
                            end
                        end
                    endcase
                    if (fin)
                        state_d = S_REPORT;
                end
            end
            S_REPORT: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (state_q == S_IDLE);
        xf_req    = (state_q == S_SEND) || (state_q == S_COLLECT);
        xf_tx     = (state_q == S_SEND) ? {1'b0, enc_word} : {1'b0, CODE_NULL};
        res_valid = (state_q == S_REPORT);
        res_data  = res_data_q;
        res_err   = res_err_q;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_NOP;
            reg_q      <= '0;
            size_q     <= '0;
            addr_q     <= '0;
            wdata_q    <= '0;
            idx_q      <= '0;
            got_q      <= '0;
            data_q     <= '0;
            res_data_q <= '0;
            res_err_q  <= ERR_NONE;
        end else begin
            if (accept) begin
                op_q    <= req_op;
                reg_q   <= req_reg;
                size_q  <= req_size;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                idx_q   <= '0;
                got_q   <= '0;
                data_q  <= '0;
            end
            if (state_q == S_SEND && xf_done)
                idx_q <= idx_q + IDX_W'(1);
            if (take) begin
                data_q <= {data_q[WORD_W-1:0], payload};
                got_q  <= got_q + RXN_W'(1);
            end
            if (fin) begin
                res_err_q  <= fin_err;
                res_data_q <= (fin_err == ERR_NONE && is_read) ? asm_data : '0;
            end
        end
    end

    AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        xf_req && !xf_done |=> xf_req && $stable(xf_tx)); // R5

    AST_TX_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        xf_req |-> !xf_tx[XF_W-1]); // R5

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !xf_req && !res_valid); // R12

    AST_TIMEOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_err == 3'(ERR_TIMEOUT) |-> $past(xf_rx) == RX_NOTRDY); // R8

    AST_BUSERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_err == 3'(ERR_BUS) |-> $past(xf_rx) == RX_BUSERR); // R9

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid && $stable(res_data) && $stable(res_err)); // R11

    AST_RESULT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $past(xf_done)); // R11

endmodule

// File: tb/sim_dbgseq_top.sv
`timescale 1ns/1ps
module sim_dbgseq_top;

    localparam int MAXR = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_op = '0;
    logic [3:0]  req_reg = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        res_valid;
    logic [31:0] res_data;
    logic [2:0]  res_err;
    logic        xf_req;
    logic [16:0] xf_tx;
    logic        xf_done = 1'b0;
    logic [16:0] xf_rx = '0;

    int vectors = 0;
    int miscompares = 0;

    dbgseq_top #(.MAX_RETRY(MAXR)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_reg(req_reg), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata),
        .res_valid(res_valid), .res_data(res_data), .res_err(res_err),
        .xf_req(xf_req), .xf_tx(xf_tx), .xf_done(xf_done), .xf_rx(xf_rx)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_cmd(input int op, input int rg, input int sz);
        int tt;
        tt = (sz == 0) ? 0 : (sz == 1) ? 64 : 128;
        case (op)
            1: return 16'(8576 + rg);
            2: return 16'(8320 + rg);
            3: return 16'(9600 + rg);
            4: return 16'(9344 + rg);
            5: return 16'(6400 + tt);
            6: return 16'(6144 + tt);
            7: return 16'h0C00;
            8: return 16'h0400;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic issue(input int op, input int rg, input int sz,
                         input logic [31:0] ad, input logic [31:0] wd);
        @(negedge clk);
        chk("R12 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_op    = 4'(op);
        req_reg   = 4'(rg);
        req_size  = 2'(sz);
        req_addr  = ad;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic xfer(input string tag, input logic [16:0] exp_tx, input logic [16:0] rx);
        @(negedge clk);
        while (!xf_req) @(negedge clk);
        chk(tag, 32'(xf_tx), 32'(exp_tx));
        xf_done = 1'b1;
        xf_rx   = rx;
        @(negedge clk);
        xf_done = 1'b0;
    endtask

    task automatic result(input string tag, input logic [31:0] ed, input int ee);
        chk({tag, " valid"}, 32'(res_valid), 32'd1);
        chk({tag, " data"}, res_data, ed);
        chk({tag, " err"}, 32'(res_err), 32'(ee));
        @(negedge clk);
        chk("R11 single strobe", 32'(res_valid), 32'd0);
        chk("R11 data held", res_data, ed);
    endtask

    task automatic send_mem_head(input int op, input int sz, input logic [31:0] ad);
        xfer("R2 mem cmd", {1'b0, exp_cmd(op, 0, sz)}, 17'h1FFFF);
        xfer("R4 addr hi", {1'b0, ad[31:16]}, 17'h10001);
        xfer("R4 addr lo", {1'b0, ad[15:0]}, 17'h00000);
    endtask

    initial begin
        int wd_cycles = 0;
        while (wd_cycles < 100000) begin
            @(posedge clk);
            wd_cycles++;
        end
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] a;
        repeat (3) @(negedge clk);
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 xf_req", 32'(xf_req), 32'd0);
        chk("R1 res_valid", 32'(res_valid), 32'd0);
        chk("R1 res_data", res_data, 32'd0);
        chk("R1 res_err", 32'(res_err), 32'd0);
        rst_n = 1'b1;

        // R2 R6 R7: register and system-register reads, every selector
        for (int op = 1; op <= 3; op += 2) begin
            for (int rg = 0; rg < 16; rg++) begin
                d = 32'h13570000 + 32'(rg * 4369) + 32'(op << 24);
                issue(op, rg, 0, 32'h0, 32'h0);
                xfer("R2 reg read cmd", {1'b0, exp_cmd(op, rg, 0)}, 17'h1FFFF);
                xfer("R7 null word", 17'h0, {1'b0, d[31:16]});
                xfer("R7 null word", 17'h0, {1'b0, d[15:0]});
                result("R7 reg read", d, 0);
            end
        end

        // R2 R4 R10: register and system-register writes
        for (int op = 2; op <= 4; op += 2) begin
            for (int rg = 0; rg < 16; rg++) begin
                d = 32'hC0DE0000 ^ 32'(rg * 65793) ^ 32'(op);
                issue(op, rg, 0, 32'h0, d);
                xfer("R2 reg write cmd", {1'b0, exp_cmd(op, rg, 0)}, 17'h10001);
                xfer("R4 wdata hi", {1'b0, d[31:16]}, 17'h1FFFF);
                xfer("R4 wdata lo", {1'b0, d[15:0]}, 17'h10005);
                xfer("R7 null word", 17'h0, 17'h0FFFF);
                result("R10 reg write", 32'h0, 0);
            end
        end

        // R3 R4 R7: memory reads at every size code
        for (int sz = 0; sz < 4; sz++) begin
            a = 32'h00A40000 + 32'(sz * 258);
            d = 32'hBEEF_7A5E + 32'(sz * 16);
            issue(5, 0, sz, a, 32'h0);
            send_mem_head(5, sz, a);
            if (sz >= 2) begin
                xfer("R7 null word", 17'h0, {1'b0, d[31:16]});
                xfer("R7 null word", 17'h0, {1'b0, d[15:0]});
                result("R3 long read", d, 0);
            end else begin
                xfer("R7 null word", 17'h0, {1'b0, d[15:0]});
                result("R3 short read", (sz == 0) ? (d & 32'hFF) : (d & 32'hFFFF), 0);
            end
        end

        // R3 R4 R10: memory writes at every size code
        for (int sz = 0; sz < 4; sz++) begin
            a = 32'h7F000010 + 32'(sz);
            d = 32'h8421_96C3 ^ 32'(sz * 4097);
            issue(6, 0, sz, a, d);
            send_mem_head(6, sz, a);
            if (sz >= 2) begin
                xfer("R4 long hi", {1'b0, d[31:16]}, 17'h10000);
                xfer("R4 long lo", {1'b0, d[15:0]}, 17'h10000);
            end else if (sz == 1) begin
                xfer("R4 word data", {1'b0, d[15:0]}, 17'h10000);
            end else begin
                xfer("R4 byte data", {1'b0, 8'h00, d[7:0]}, 17'h10000);
            end
            xfer("R7 null word", 17'h0, 17'h0FFFF);
            result("R10 mem write", 32'h0, 0);
        end

        // R2: resume, peripheral reset, null, and unused codes
        for (int op = 7; op <= 12; op++) begin
            issue(op, 5, 2, 32'hFFFFFFFF, 32'hFFFFFFFF);
            xfer("R2 single-word cmd", {1'b0, exp_cmd(op, 5, 2)}, 17'h1FFFF);
            xfer("R7 null word", 17'h0, 17'h0FFFF);
            result("R10 single-word op", 32'h0, 0);
        end
        issue(0, 9, 1, 32'h0, 32'h0);
        xfer("R2 null cmd", 17'h0, 17'h00000);
        xfer("R7 null word", 17'h0, 17'h0FFFF);
        result("R10 null op", 32'h0, 0);

        // R8: retries up to the limit succeed
        for (int k = 0; k <= MAXR; k++) begin
            d = 32'h0000_4D00 + 32'(k);
            issue(5, 0, 1, 32'h100, 32'h0);
            send_mem_head(5, 1, 32'h100);
            for (int j = 0; j < k; j++) xfer("R8 retry null", 17'h0, 17'h10000);
            xfer("R8 null word", 17'h0, {1'b0, d[15:0]});
            result("R8 retried read", d, 0);
        end

        // R8: one more not-ready is a timeout
        issue(5, 0, 1, 32'h100, 32'h0);
        send_mem_head(5, 1, 32'h100);
        for (int j = 0; j <= MAXR; j++) xfer("R8 retry null", 17'h0, 17'h10000);
        result("R8 timeout", 32'h0, 3);

        // R8: count restarts after each data word
        d = 32'h2468ACE0;
        issue(1, 4, 0, 32'h0, 32'h0);
        xfer("R2 reg read cmd", {1'b0, exp_cmd(1, 4, 0)}, 17'h00000);
        for (int j = 0; j < MAXR; j++) xfer("R8 retry null", 17'h0, 17'h10000);
        xfer("R8 null word", 17'h0, {1'b0, d[31:16]});
        for (int j = 0; j < MAXR; j++) xfer("R8 retry null", 17'h0, 17'h10000);
        xfer("R8 null word", 17'h0, {1'b0, d[15:0]});
        result("R8 per-word retry", d, 0);

        // R8: non-read op retried then completes
        issue(7, 0, 0, 32'h0, 32'h0);
        xfer("R2 resume cmd", 17'h00C00, 17'h00000);
        for (int j = 0; j < MAXR; j++) xfer("R8 retry null", 17'h0, 17'h10000);
        xfer("R8 null word", 17'h0, 17'h0FFFF);
        result("R8 retried resume", 32'h0, 0);

        // R9: bus error, illegal, other flagged pattern
        issue(1, 2, 0, 32'h0, 32'h0);
        xfer("R2 reg read cmd", {1'b0, exp_cmd(1, 2, 0)}, 17'h00000);
        xfer("R9 null word", 17'h0, 17'h10001);
        result("R9 bus error", 32'h0, 1);

        issue(1, 2, 0, 32'h0, 32'h0);
        xfer("R2 reg read cmd", {1'b0, exp_cmd(1, 2, 0)}, 17'h00000);
        xfer("R9 null word", 17'h0, 17'h01234);
        xfer("R9 null word", 17'h0, 17'h10001);
        result("R9 bus error after data", 32'h0, 1);

        issue(6, 0, 2, 32'h4000, 32'h11112222);
        send_mem_head(6, 2, 32'h4000);
        xfer("R4 long hi", 17'h01111, 17'h0);
        xfer("R4 long lo", 17'h02222, 17'h0);
        xfer("R9 null word", 17'h0, 17'h1FFFF);
        result("R9 illegal", 32'h0, 2);

        issue(0, 0, 0, 32'h0, 32'h0);
        xfer("R2 null cmd", 17'h0, 17'h0);
        xfer("R9 null word", 17'h0, 17'h10005);
        result("R9 protocol", 32'h0, 4);

        // R10: non-read op given a plain data word
        issue(8, 0, 0, 32'h0, 32'h0);
        xfer("R2 periph reset cmd", 17'h00400, 17'h0);
        xfer("R10 null word", 17'h0, 17'h01234);
        result("R10 protocol", 32'h0, 4);

        // R12: request while busy is ignored
        d = 32'h5A5A0F0F;
        issue(2, 6, 0, 32'h0, d);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 4'd7;
        chk("R12 ready low while busy", 32'(req_ready), 32'd0);
        xfer("R12 cmd kept", {1'b0, exp_cmd(2, 6, 0)}, 17'h0);
        xfer("R12 wdata hi kept", {1'b0, d[31:16]}, 17'h0);
        xfer("R12 wdata lo kept", {1'b0, d[15:0]}, 17'h0);
        req_valid = 1'b0;
        xfer("R12 null word", 17'h0, 17'h0FFFF);
        result("R12 write unaffected", 32'h0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule